// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Mask Unit

This unit collects one-cycle event pulses from an I2C transfer engine into a sticky 16-bit status word. It qualifies that word with an enable mask and drives a single level-sensitive interrupt line. Software clears a status bit by writing a one to it.

The enable mask has no direct write path. Software changes it only by writing a mask to a set address, which turns bits on, or to a clear address, which turns bits off. The status word also carries one live bit that follows the bus-busy input. That bit is never latched and never interrupts.

The register side is a plain strobe interface with a 2-bit address, a write strobe, write data and combinational read data. The unit has no streaming interface, so no back-pressure rules apply.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset, the status read (address 0) returns 0 while bus_busy is low, the enable read (address 1) returns 0, and irq is low.
- R2: A high bit on ev_pulse at a clock edge sets the matching latched status bit, which reads 1 from the next cycle. This happens whatever the state of the enable mask.
- R3: A write to address 0 clears every latched status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R5: A write to address 2 sets the enable bits marked by ones in the write data and leaves the other enable bits alone.
- R6: A write to address 3 clears the enable bits marked by ones in the write data. Writing 0xFFFF there leaves the enable read at 0.
- R7: A write to address 1 changes neither the enable mask nor the status word.
- R8: Status bit 12 reads the present value of bus_busy in the same cycle. A write to it has no effect, and it never drives irq.
- R9: irq is high exactly when some latched status bit and its enable bit are both 1. It updates in the cycle after the edge that changed either one.
- R10: The bit positions are:
  - bit 0: arbitration lost
  - bit 1: no acknowledge
  - bit 2: transfer complete
  - bit 3: receive ready
  - bit 4: transmit ready
  - bit 8: bus free
  - bit 13: receive draining
  - bit 14: transmit draining

  The same positions apply in the status word and the enable mask.
- R11: Bits outside the event set 0x611F never latch or enable. Pulsing or enabling all 16 bits reads back 0x611F. Reads at addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_pulse | input | 16 | One-cycle event pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-occupied indication |
| reg_addr | input | 2 | Register address: 0 status, 1 enable read, 2 enable set, 3 enable clear |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data / mask |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
A pulse or write that is present at a rising edge updates the status or enable register at that edge. The read data and irq are combinational from those registers, so both results are due one cycle after the stimulus. The busy bit is the exception: it follows its input within the same cycle. The bench drives inputs on the falling edge and lets exactly one rising edge pass. It then samples on the next falling edge, and for the busy bit it samples shortly after changing the input, with no edge in between.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int IC_W = 16;
  localparam int IC_AW = 2;
  localparam logic [IC_W-1:0] IC_LATCH_MASK = 16'h611F;
  localparam int IC_BUSY_BIT = 12;

  localparam int EV_ARB_LOST  = 0;
  localparam int EV_NO_ACK    = 1;
  localparam int EV_XFER_DONE = 2;
  localparam int EV_RX_READY  = 3;
  localparam int EV_TX_READY  = 4;
  localparam int EV_BUS_FREE  = 8;
  localparam int EV_RX_DRAIN  = 13;
  localparam int EV_TX_DRAIN  = 14;

  typedef enum logic [IC_AW-1:0] {
    A_STATUS = 2'd0,
    A_EN_READ = 2'd1,
    A_EN_SET = 2'd2,
    A_EN_CLR = 2'd3
  } ic_addr_e;

  typedef struct packed {
    logic status_w1c;
    logic en_set;
    logic en_clr;
  } ic_wr_t;
endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
  import i2c_irq_pkg::*;
(
  input  logic             wr,
  input  logic [IC_AW-1:0] addr,
  output ic_wr_t           sel
);
  always_comb begin
    sel = '0;
    if (wr) begin
      unique case (ic_addr_e'(addr))
        A_STATUS: sel.status_w1c = 1'b1;
        A_EN_SET: sel.en_set = 1'b1;
        A_EN_CLR: sel.en_clr = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int W = 16,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr_stb,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_v;
  logic [W-1:0] nxt;

  always_comb begin
    clr_v = clr_stb ? clr_mask : '0;
    // an event in the same cycle overrides the clear
    nxt = ((q & ~clr_v) | ev) & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/i2c_irq_enable.sv
module i2c_irq_enable #(
  parameter int W = 16,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (set_stb) nxt = nxt | mask;
    if (clr_stb) nxt = nxt & ~mask;
    nxt = nxt & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IC_W-1:0]  ev_pulse,
  input  logic             bus_busy,
  input  logic [IC_AW-1:0] reg_addr,
  input  logic             reg_wr,
  input  logic [IC_W-1:0]  reg_wdata,
  output logic [IC_W-1:0]  reg_rdata,
  output logic             irq
);
  localparam logic [IC_W-1:0] BUSY_ONEHOT = IC_W'(1) << IC_BUSY_BIT;
  localparam logic [IC_W-1:0] KEEP = IC_LATCH_MASK & ~BUSY_ONEHOT;

  ic_wr_t sel;
  logic [IC_W-1:0] status_q;
  logic [IC_W-1:0] enable_q;

  i2c_irq_decode u_dec (
    .wr(reg_wr), .addr(reg_addr), .sel(sel)
  );

  i2c_irq_status #(.W(IC_W), .KEEP(KEEP)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev_pulse),
    .clr_stb(sel.status_w1c), .clr_mask(reg_wdata), .q(status_q)
  );

  i2c_irq_enable #(.W(IC_W), .KEEP(KEEP)) u_en (
    .clk(clk), .rst_n(rst_n), .set_stb(sel.en_set),
    .clr_stb(sel.en_clr), .mask(reg_wdata), .q(enable_q)
  );

  always_comb begin
    unique case (ic_addr_e'(reg_addr))
      A_STATUS:  reg_rdata = status_q | (bus_busy ? BUSY_ONEHOT : '0);
      A_EN_READ: reg_rdata = enable_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |(status_q & enable_q);
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [IC_W-1:0]  ev_pulse,
  input logic             reg_wr,
  input logic [IC_AW-1:0] reg_addr,
  input logic [IC_W-1:0]  reg_wdata,
  input logic [IC_W-1:0]  status_q,
  input logic [IC_W-1:0]  enable_q,
  input logic             irq
);
  // R2: a latched event is visible after the edge
  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_pulse & IC_LATCH_MASK) != '0) |=>
      ((status_q & $past(ev_pulse & IC_LATCH_MASK)) == $past(ev_pulse & IC_LATCH_MASK)));

  // R3: cleared bits with no competing event drop
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=>
      ((status_q & $past(reg_wdata & ~ev_pulse)) == '0));

  // R5: set address turns enables on
  p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=>
      ((enable_q & $past(reg_wdata & IC_LATCH_MASK)) == $past(reg_wdata & IC_LATCH_MASK)));

  // R6: clear address turns enables off
  p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> ((enable_q & $past(reg_wdata)) == '0));

  // R7: no direct write to the enable mask
  p_no_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> $stable(enable_q));

  // R9: interrupt only with an enabled latched bit
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status_q & enable_q) != '0));

  // R8 and R11: busy and reserved bits never stored
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~IC_LATCH_MASK) == '0) && ((enable_q & ~IC_LATCH_MASK) == '0)
    && !status_q[IC_BUSY_BIT]);
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_q(status_q),
  .enable_q(enable_q), .irq(irq)
);

// File: tb/sim_i2c_irq_ctrl.sv
module sim_i2c_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_pulse = '0;
  logic        bus_busy = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .bus_busy(bus_busy),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, let one rising edge pass
  task automatic cyc(logic [15:0] ev, logic wr, logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    ev_pulse = ev; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    ev_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic chk_rd(string req, logic [1:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic wipe();
    cyc('0, 1'b1, 2'd0, 16'hFFFF);
    cyc('0, 1'b1, 2'd3, 16'hFFFF);
  endtask

  task automatic t_reset();
    chk_rd("R1 status", 2'd0, 16'h0000);
    chk_rd("R1 enable", 2'd1, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_latch();
    cyc(16'h0002, 1'b0, 2'd0, '0);
    chk_rd("R2 latch no-ack with mask off", 2'd0, 16'h0002);
    chk("R2 irq stays low", {15'b0, irq}, 16'h0);
    cyc(16'h0018, 1'b0, 2'd0, '0);
    chk_rd("R2 accumulate", 2'd0, 16'h001A);
  endtask

  task automatic t_w1c();
    cyc('0, 1'b1, 2'd0, 16'h0010);
    chk_rd("R3 clear one bit", 2'd0, 16'h000A);
    cyc('0, 1'b1, 2'd0, 16'h0000);
    chk_rd("R3 zero write keeps", 2'd0, 16'h000A);
    cyc('0, 1'b1, 2'd0, 16'hFFFF);
    chk_rd("R3 clear all", 2'd0, 16'h0000);
  endtask

  task automatic t_collide();
    cyc(16'h0001, 1'b0, 2'd0, '0);
    cyc(16'h0004, 1'b1, 2'd0, 16'h0005);
    chk_rd("R4 event beats clear", 2'd0, 16'h0004);
    wipe();
  endtask

  task automatic t_enable();
    cyc('0, 1'b1, 2'd2, 16'h0003);
    chk_rd("R5 set", 2'd1, 16'h0003);
    cyc('0, 1'b1, 2'd2, 16'h0100);
    chk_rd("R5 set keeps others", 2'd1, 16'h0103);
    cyc('0, 1'b1, 2'd3, 16'h0001);
    chk_rd("R6 clear one", 2'd1, 16'h0102);
    cyc('0, 1'b1, 2'd3, 16'hFFFF);
    chk_rd("R6 clear all", 2'd1, 16'h0000);
  endtask

  task automatic t_direct();
    cyc('0, 1'b1, 2'd2, 16'h0010);
    cyc(16'h0002, 1'b0, 2'd0, '0);
    cyc('0, 1'b1, 2'd1, 16'hFFFF);
    chk_rd("R7 enable unchanged by addr 1 ones", 2'd1, 16'h0010);
    chk_rd("R7 status unchanged by addr 1", 2'd0, 16'h0002);
    cyc('0, 1'b1, 2'd1, 16'h0000);
    chk_rd("R7 enable unchanged by addr 1 zeros", 2'd1, 16'h0010);
    wipe();
  endtask

  task automatic t_busy();
    @(negedge clk);
    bus_busy = 1'b1;
    chk_rd("R8 busy live high", 2'd0, 16'h1000);
    cyc('0, 1'b1, 2'd2, 16'hFFFF);
    cyc('0, 1'b1, 2'd0, 16'h1000);
    chk_rd("R8 write to busy ignored", 2'd0, 16'h1000);
    chk("R8 busy gives no irq", {15'b0, irq}, 16'h0);
    bus_busy = 1'b0;
    chk_rd("R8 busy live low", 2'd0, 16'h0000);
    wipe();
  endtask

  task automatic t_irq();
    cyc('0, 1'b1, 2'd2, 16'h0008);
    cyc(16'h0010, 1'b0, 2'd0, '0);
    chk("R9 masked event low", {15'b0, irq}, 16'h0);
    cyc(16'h0008, 1'b0, 2'd0, '0);
    chk("R9 enabled event high", {15'b0, irq}, 16'h1);
    cyc('0, 1'b1, 2'd0, 16'h0008);
    chk("R9 low after status clear", {15'b0, irq}, 16'h0);
    cyc(16'h0008, 1'b0, 2'd0, '0);
    cyc('0, 1'b1, 2'd3, 16'h0008);
    chk("R9 low after enable clear", {15'b0, irq}, 16'h0);
    wipe();
  endtask

  task automatic t_positions();
    int pos [8] = '{0, 1, 2, 3, 4, 8, 13, 14};
    foreach (pos[i]) begin
      logic [15:0] b = 16'(1) << pos[i];
      cyc(b, 1'b0, 2'd0, '0);
      chk_rd("R10 status position", 2'd0, b);
      cyc('0, 1'b1, 2'd2, b);
      chk_rd("R10 enable position", 2'd1, b);
      chk("R10 irq from position", {15'b0, irq}, 16'h1);
      wipe();
    end
  endtask

  task automatic t_reserved();
    cyc(16'hFFFF, 1'b0, 2'd0, '0);
    chk_rd("R11 status reserved", 2'd0, 16'h611F);
    cyc('0, 1'b1, 2'd2, 16'hFFFF);
    chk_rd("R11 enable reserved", 2'd1, 16'h611F);
    chk_rd("R11 addr 2 reads zero", 2'd2, 16'h0000);
    chk_rd("R11 addr 3 reads zero", 2'd3, 16'h0000);
    wipe();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_w1c();
    t_collide();
    t_enable();
    t_direct();
    t_busy();
    t_irq();
    t_positions();
    t_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule